// File: doc/BRIEF.md
# Debug Communications Mailbox Channel

This block lets a processor core and an external debugger pass 32-bit words to each other. It pairs two single-entry slots that run in opposite directions. The outbound slot carries words from the core to the debugger. The inbound slot carries words from the debugger to the core. A status word with two handshake flags tells each side when it may write and when it must wait.

The core reaches the block through a register-transfer port. An index picks the register, and read and write strobes start the access. Index 0 returns the status word. At index 1, a core write fills the outbound slot and a core read drains the inbound slot. A qualifier input says whether the core is in its full-width instruction state. Core accesses made outside that state do nothing and return zero.

The debugger has a plain parallel port. It has a read strobe that drains the outbound slot, a write strobe that fills the inbound slot, and a direct view of both flags. The filling side sets a flag and only the draining side clears it, so neither side can overwrite a word the other has not yet taken. Every output is registered.

Top module: `dcc_mailbox`

## Requirements
- R1: A synchronous active-high reset clears both data slots, both flags, both read-data outputs and both overrun pulses. The reset takes priority over any strobe active in the same cycle.
- R2: A core read at index 0 returns the status word on `cpu_rdata` one cycle later. In that word, bit 0 is the inbound-pending flag (R), bit 1 is the outbound-pending flag (W), and every other bit is zero. `dbg_flags` shows the same two flags at the same bit positions.
- R3: A core write at index 1 while W is clear stores `cpu_wdata` in the outbound slot and sets W on the next clock.
- R4: A debugger read returns the outbound word on `dbg_rdata` one cycle later and clears W.
- R5: A debugger write while R is clear stores `dbg_wdata` in the inbound slot and sets R on the next clock.
- R6: A core read at index 1 returns the inbound word on `cpu_rdata` one cycle later and clears R.
- R7: When a fill and a drain hit the same slot in the same cycle and the flag is clear, the fill wins. The flag ends up set, and the drain returns the word that was held before the fill.
- R8: A write to a slot whose flag is already set is ignored, and the held word is kept. The overrun pulse for that side (`cpu_ovr` for the core, `dbg_ovr` for the debugger) is high for exactly the one following cycle.
- R9: While `cpu_wide` is low, core reads return zero, and core writes change neither slot nor flag and raise no overrun pulse.
- R10: `cpu_rdata` is zero in the cycle after any cycle with no valid core read, and `dbg_rdata` is zero in the cycle after any cycle with no debugger read. A core read at an index other than 0 or 1 returns zero. A core write at such an index is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wide | input | 1 | High when the core is in its full-width instruction state |
| cpu_idx | input | IDX_W | Core register index (0 = status, 1 = data) |
| cpu_rd | input | 1 | Core read strobe |
| cpu_wr | input | 1 | Core write strobe |
| cpu_wdata | input | DATA_W | Core write data |
| cpu_rdata | output | DATA_W | Core read data, registered |
| cpu_ovr | output | 1 | Pulse: core wrote while W was set |
| dbg_rd | input | 1 | Debugger read strobe for the outbound slot |
| dbg_wr | input | 1 | Debugger write strobe for the inbound slot |
| dbg_wdata | input | DATA_W | Debugger write data |
| dbg_rdata | output | DATA_W | Debugger read data, registered |
| dbg_flags | output | 2 | Bit 0 = R, bit 1 = W |
| dbg_ovr | output | 1 | Pulse: debugger wrote while R was set |

## Verification
Every result of this block is due exactly one clock after the strobe that causes it. This holds for flag changes, read data and overrun pulses. The bench drives each strobe on a falling edge and pushes every expected value into a queue, tagged with the cycle number one edge later. A monitor wakes just after each rising edge, pops the entries due in that cycle and compares them. Any entry that is found late, or is still in the queue at the end, counts as a failure.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int unsigned FLAG_R_BIT = 0;
  localparam int unsigned FLAG_W_BIT = 1;
  localparam int unsigned IDX_STATUS = 0;
  localparam int unsigned IDX_DATA   = 1;
endpackage

// File: rtl/dcc_slot.sv
module dcc_slot #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              drain,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output logic              ovr_q
);
  logic accept;
  assign accept = fill & ~full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (accept) data_q <= fill_data;
      if (accept)     full_q <= 1'b1;
      else if (drain) full_q <= 1'b0;
      ovr_q <= fill & full_q;
    end
  end

  // R3 and R5: an accepted fill sets the flag and captures the word
  p_fill_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (fill && !full_q) |=> (full_q && data_q == $past(fill_data)));
  // R4 and R6: a drain with no fill leaves the slot empty
  p_drain_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (drain && !fill) |=> !full_q);
  // R7: fill beats drain in the same cycle
  p_fill_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (fill && drain && !full_q) |=> full_q);
  // R8: held word survives a blocked fill, pulse lasts one cycle
  p_no_overwrite_r8: assert property (@(posedge clk) disable iff (rst)
    (fill && full_q) |=> ($stable(data_q) && ovr_q));
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    !(fill && full_q) |=> !ovr_q);
endmodule

// File: rtl/dcc_cpu_port.sv
module dcc_cpu_port #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wide,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] status_word,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_fill,
  output logic              in_drain,
  output logic [DATA_W-1:0] cpu_rdata
);
  import dcc_pkg::*;
  localparam logic [IDX_W-1:0] SEL_STATUS = IDX_W'(IDX_STATUS);
  localparam logic [IDX_W-1:0] SEL_DATA   = IDX_W'(IDX_DATA);

  logic rd_ok, wr_ok;
  logic [DATA_W-1:0] rd_mux;

  assign rd_ok    = cpu_rd & cpu_wide;
  assign wr_ok    = cpu_wr & cpu_wide;
  assign out_fill = wr_ok & (cpu_idx == SEL_DATA);
  assign in_drain = rd_ok & (cpu_idx == SEL_DATA);

  always_comb begin
    rd_mux = '0;
    if (rd_ok) begin
      if (cpu_idx == SEL_STATUS)    rd_mux = status_word;
      else if (cpu_idx == SEL_DATA) rd_mux = in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else     cpu_rdata <= rd_mux;
  end

  // R9: narrow-state accesses read as zero
  p_narrow_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !cpu_wide |=> (cpu_rdata == '0));
  // R10: no read strobe, zero data next cycle
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> (cpu_rdata == '0));
endmodule

// File: rtl/dcc_mailbox.sv
module dcc_mailbox #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wide,
  input  logic [IDX_W-1:0]  cpu_idx,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ovr,
  input  logic              dbg_rd,
  input  logic              dbg_wr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic [1:0]        dbg_flags,
  output logic              dbg_ovr
);
  import dcc_pkg::*;

  logic              out_fill, in_drain;
  logic              out_full, in_full;
  logic [DATA_W-1:0] out_data, in_data;
  logic [DATA_W-1:0] status_word;

  always_comb begin
    status_word = '0;
    status_word[FLAG_R_BIT] = in_full;
    status_word[FLAG_W_BIT] = out_full;
  end

  dcc_cpu_port #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cpu (
    .clk(clk), .rst(rst), .cpu_wide(cpu_wide), .cpu_idx(cpu_idx),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .status_word(status_word),
    .in_data(in_data), .out_fill(out_fill), .in_drain(in_drain),
    .cpu_rdata(cpu_rdata)
  );

  dcc_slot #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .fill(out_fill), .fill_data(cpu_wdata),
    .drain(dbg_rd), .data_q(out_data), .full_q(out_full), .ovr_q(cpu_ovr)
  );

  dcc_slot #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst(rst), .fill(dbg_wr), .fill_data(dbg_wdata),
    .drain(in_drain), .data_q(in_data), .full_q(in_full), .ovr_q(dbg_ovr)
  );

  always_ff @(posedge clk) begin
    if (rst) dbg_rdata <= '0;
    else     dbg_rdata <= dbg_rd ? out_data : '0;
  end

  assign dbg_flags[FLAG_R_BIT] = in_full;
  assign dbg_flags[FLAG_W_BIT] = out_full;

  // R4: debugger read yields the held outbound word
  p_dbg_read_r4: assert property (@(posedge clk) disable iff (rst)
    dbg_rd |=> (dbg_rdata == $past(out_data)));
  // R9: narrow-state core write raises no overrun
  p_narrow_no_ovr_r9: assert property (@(posedge clk) disable iff (rst)
    !cpu_wide |=> !cpu_ovr);
  // R1: reset empties both slots
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (dbg_flags == 2'b00 && cpu_rdata == '0 && dbg_rdata == '0));
endmodule

// File: tb/dcc_mailbox_tb.sv
module dcc_mailbox_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int IW = 2;

  localparam int S_CRD = 0, S_DRD = 1, S_FLG = 2, S_COVR = 3, S_DOVR = 4;

  typedef struct {
    int          due;
    int          sig;
    logic [31:0] val;
  } exp_t;

  logic clk = 1'b0;
  logic rst, cpu_wide, cpu_rd, cpu_wr, dbg_rd, dbg_wr;
  logic [IW-1:0] cpu_idx;
  logic [DW-1:0] cpu_wdata, dbg_wdata, cpu_rdata, dbg_rdata;
  logic [1:0]    dbg_flags;
  logic          cpu_ovr, dbg_ovr;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  exp_t  q[$];
  string nq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dcc_mailbox #(.DATA_W(DW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst(rst), .cpu_wide(cpu_wide), .cpu_idx(cpu_idx),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ovr(cpu_ovr), .dbg_rd(dbg_rd),
    .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .dbg_flags(dbg_flags), .dbg_ovr(dbg_ovr)
  );

  function automatic logic [31:0] observe(int sig);
    case (sig)
      S_CRD:   return cpu_rdata;
      S_DRD:   return dbg_rdata;
      S_FLG:   return {30'd0, dbg_flags};
      S_COVR:  return {31'd0, cpu_ovr};
      default: return {31'd0, dbg_ovr};
    endcase
  endfunction

  // monitor: compares items due in the cycle that just began
  always @(posedge clk) begin
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      string n;
      logic [31:0] a;
      e = q.pop_front();
      n = nq.pop_front();
      a = observe(e.sig);
      checks++;
      if (e.due != cyc) begin
        errors++;
        $display("FAIL %s sig%0d missed at cycle %0d (due %0d)", n, e.sig, cyc, e.due);
      end else if (a !== e.val) begin
        errors++;
        $display("FAIL %s sig%0d actual %h expected %h", n, e.sig, a, e.val);
      end
    end
  end

  task automatic go(input logic r, input logic wide, input logic [IW-1:0] idx,
                    input logic crd, input logic cwr, input logic [DW-1:0] cwd,
                    input logic drd, input logic dwr, input logic [DW-1:0] dwd);
    @(negedge clk);
    rst = r; cpu_wide = wide; cpu_idx = idx; cpu_rd = crd; cpu_wr = cwr;
    cpu_wdata = cwd; dbg_rd = drd; dbg_wr = dwr; dbg_wdata = dwd;
  endtask

  task automatic idle();
    go(0, 1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic expect_nx(input int sig, input logic [31:0] v, input string n);
    exp_t e;
    e.due = cyc + 1; e.sig = sig; e.val = v;
    q.push_back(e);
    nq.push_back(n);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    go(1, 1, 0, 0, 0, 0, 0, 0, 0);
    go(1, 1, 0, 0, 0, 0, 0, 0, 0);
    // R1 reset state
    idle();
    expect_nx(S_FLG, 0, "R1 flags"); expect_nx(S_CRD, 0, "R1 cpu_rdata");
    expect_nx(S_DRD, 0, "R1 dbg_rdata"); expect_nx(S_COVR, 0, "R1 cpu_ovr");
    // R3 core write sets W
    go(0, 1, 1, 0, 1, 32'hA1A1_0001, 0, 0, 0);
    expect_nx(S_FLG, 2, "R3 W set"); expect_nx(S_COVR, 0, "R3 no ovr");
    // R2 status read with W set
    go(0, 1, 0, 1, 0, 0, 0, 0, 0);
    expect_nx(S_CRD, 32'h2, "R2 status W");
    // R8 core overwrite attempt
    go(0, 1, 1, 0, 1, 32'hBBBB_0002, 0, 0, 0);
    expect_nx(S_COVR, 1, "R8 cpu_ovr pulse"); expect_nx(S_FLG, 2, "R8 W held");
    idle();
    expect_nx(S_COVR, 0, "R8 cpu_ovr one cycle"); expect_nx(S_CRD, 0, "R10 idle cpu_rdata");
    // R4 debugger read, R8 first word kept
    go(0, 1, 0, 0, 0, 0, 1, 0, 0);
    expect_nx(S_DRD, 32'hA1A1_0001, "R4/R8 dbg_rdata"); expect_nx(S_FLG, 0, "R4 W clear");
    idle();
    expect_nx(S_DRD, 0, "R10 idle dbg_rdata");
    // R5 debugger write
    go(0, 1, 0, 0, 0, 0, 0, 1, 32'hC0C0_0003);
    expect_nx(S_FLG, 1, "R5 R set");
    go(0, 1, 0, 1, 0, 0, 0, 0, 0);
    expect_nx(S_CRD, 32'h1, "R2 status R");
    // R8 debugger overwrite attempt
    go(0, 1, 0, 0, 0, 0, 0, 1, 32'hDDDD_0004);
    expect_nx(S_DOVR, 1, "R8 dbg_ovr pulse"); expect_nx(S_FLG, 1, "R8 R held");
    // R6 core read incoming
    go(0, 1, 1, 1, 0, 0, 0, 0, 0);
    expect_nx(S_CRD, 32'hC0C0_0003, "R6 cpu_rdata"); expect_nx(S_FLG, 0, "R6 R clear");
    expect_nx(S_DOVR, 0, "R8 dbg_ovr one cycle");
    // R7 fill wins on inbound slot
    go(0, 1, 1, 1, 0, 0, 0, 1, 32'hE0E0_0005);
    expect_nx(S_CRD, 32'hC0C0_0003, "R7 old inbound word"); expect_nx(S_FLG, 1, "R7 R set");
    // R7 fill wins on outbound slot
    go(0, 1, 1, 0, 1, 32'hF0F0_0006, 1, 0, 0);
    expect_nx(S_DRD, 32'hA1A1_0001, "R7 old outbound word"); expect_nx(S_FLG, 3, "R7 W set");
    // R9 narrow state
    go(0, 0, 1, 1, 0, 0, 0, 0, 0);
    expect_nx(S_CRD, 0, "R9 narrow data read"); expect_nx(S_FLG, 3, "R9 R kept");
    go(0, 0, 0, 1, 1, 32'h1234_5678, 0, 0, 0);
    expect_nx(S_CRD, 0, "R9 narrow status read"); expect_nx(S_COVR, 0, "R9 no ovr");
    go(0, 1, 0, 0, 0, 0, 1, 0, 0);
    expect_nx(S_DRD, 32'hF0F0_0006, "R4 second word"); expect_nx(S_FLG, 1, "R4 W clear");
    go(0, 0, 1, 0, 1, 32'h9999_0007, 0, 0, 0);
    expect_nx(S_FLG, 1, "R9 narrow write no W");
    go(0, 1, 0, 0, 0, 0, 1, 0, 0);
    expect_nx(S_DRD, 32'hF0F0_0006, "R9 outbound unchanged");
    // R10 unused index
    go(0, 1, 2, 1, 0, 0, 0, 0, 0);
    expect_nx(S_CRD, 0, "R10 index 2 read");
    go(0, 1, 2, 0, 1, 32'h7777_0008, 0, 0, 0);
    expect_nx(S_FLG, 1, "R10 index 2 write ignored");
    go(0, 1, 1, 1, 0, 0, 0, 0, 0);
    expect_nx(S_CRD, 32'hE0E0_0005, "R6 fill-won word"); expect_nx(S_FLG, 0, "R6 R clear");
    // R1 reset overrides strobes
    go(0, 1, 1, 0, 1, 32'h5555_0009, 0, 1, 32'h6666_000A);
    expect_nx(S_FLG, 3, "R3/R5 both set");
    go(1, 1, 0, 1, 0, 0, 1, 0, 0);
    expect_nx(S_FLG, 0, "R1 mid reset flags"); expect_nx(S_CRD, 0, "R1 mid reset cpu_rdata");
    expect_nx(S_DRD, 0, "R1 mid reset dbg_rdata");
    go(0, 1, 1, 1, 0, 0, 1, 0, 0);
    expect_nx(S_CRD, 0, "R1 inbound cleared"); expect_nx(S_DRD, 0, "R1 outbound cleared");
    idle(); idle(); idle();
    if (q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard leftover %0d expected 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule